// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer with Segment Parking

This block produces 2-bit drive-level codes for a multiplexed LCD panel with four common lines, quarter duty and third bias, plus a parameterised number of segment lines. Code 0 through code 3 stand for the four bias voltages from 0 V up to 3 V. A separate analog stage turns the codes into voltages. The sequencer walks through an eight-phase frame, advancing on a slow enable tick that comes from a real-time clock. Each phase lasts a programmable number of ticks.

To cut the charge moved at every transition, the segments can be parked at the shared non-selected common level for a programmable number of ticks at the start of each phase. Only after that interval are they driven to their data level. Pixel data, the phase length, the park length and the park enable are all sampled once per frame. A frame therefore never mixes old and new settings.

Top module: `lcd_mux_seq`

## Requirements
- R1: After the active-low asynchronous reset, and until the first tick, `phase` is 0 and every common and segment code is 2.
- R2: The first tick starts a frame at phase 0. After that, each phase lasts `phaseLen` ticks (a value of 0 acts as 1), and the phases count 0 to 7 and then wrap to 0.
- R3: Common k (codes at bits 2k+1:2k of `comLevel`) is selected during phases 2k and 2k+1. It is driven to code 0 on the even phase and code 3 on the odd phase.
- R4: In every running phase, the three unselected commons share one code: 2 on even phases and 1 on odd phases.
- R5: Segment s uses pixel bit `pixData[c*NUM_SEG+s]` for common c. When that bit is 1 for the selected common, the segment is driven to code 3 on even phases and code 0 on odd phases. When it is 0, the segment is driven to code 1 on even phases and code 2 on odd phases.
- R6: With parking enabled, every segment sits at code 2 (even phase) or code 1 (odd phase) for the first `parkLen` ticks of each phase, and is then driven to its R5 level. A `parkLen` of 0 means no parking.
- R7: With parking disabled, segments take their R5 level from the first tick of each phase.
- R8: A `parkLen` equal to or greater than the effective phase length is treated as the phase length minus one.
- R9: `pixData`, `phaseLen`, `parkLen` and `parkEn` are sampled only on the tick that starts a frame: the first tick after reset, or the tick that ends phase 7.
- R10: Outputs and sequencer position change only in the clock cycle after a tick. Without a tick they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable from the real-time clock |
| phaseLen | input | CNT_W | Ticks per phase |
| parkLen | input | CNT_W | Ticks of segment parking at phase start |
| parkEn | input | 1 | Enables segment parking |
| pixData | input | 4*NUM_SEG | Pixel bits, row per common |
| phase | output | 3 | Current phase number |
| comLevel | output | 8 | Level codes of the four commons |
| segLevel | output | 2*NUM_SEG | Level codes of the segments |

## Verification
Every result of the block is due in the cycle right after the clock edge that samples a tick: the phase number, the common codes and the segment codes all come from registers updated on that edge, with no further pipeline stage. The bench raises `tick` on a falling edge, lowers it on the next falling edge, and compares all three outputs at that point against a frame model kept in the bench. Idle gaps of several cycles between ticks are also checked, to confirm that nothing moves without a tick. Configuration changes land in mid-frame on purpose, so that the model's frame-boundary sampling is compared against the design's.

// File: rtl/lcd_mux_seq_pkg.sv
package lcd_mux_seq_pkg;
  localparam int NUM_COM = 4;
  localparam int NUM_PHASE = 2 * NUM_COM;
  localparam int PH_W = $clog2(NUM_PHASE);

  localparam logic [1:0] LVL_0V = 2'd0;
  localparam logic [1:0] LVL_1V = 2'd1;
  localparam logic [1:0] LVL_2V = 2'd2;
  localparam logic [1:0] LVL_3V = 2'd3;

  typedef struct packed {
    logic            active;
    logic [PH_W-1:0] phase;
    logic            park;
    logic            loadPix;
  } seqCtrl_t;
endpackage

// File: rtl/lcd_mux_seq_ctrl.sv
module lcd_mux_seq_ctrl
  import lcd_mux_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] phaseLen,
  input  logic [CNT_W-1:0] parkLen,
  input  logic             parkEn,
  output seqCtrl_t         ctrl
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(NUM_PHASE - 1);

  logic             started;
  logic [PH_W-1:0]  phaseReg;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lenReg;
  logic [CNT_W-1:0] parkCnt;
  logic             enReg;

  logic [CNT_W-1:0] inLen;
  logic [CNT_W-1:0] inPark;
  logic             lastTick;
  logic             frameLoad;

  // Effective lengths, clamped when a frame loads them
  assign inLen = (phaseLen == '0) ? ONE : phaseLen;
  assign inPark = (parkLen >= inLen) ? (inLen - ONE) : parkLen;

  assign lastTick = (tickCnt == lenReg - ONE);
  assign frameLoad = tick && (!started || (phaseReg == LAST_PHASE && lastTick));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      phaseReg <= '0;
      tickCnt  <= '0;
      lenReg   <= ONE;
      parkCnt  <= '0;
      enReg    <= 1'b0;
    end else if (tick) begin
      if (frameLoad) begin
        lenReg  <= inLen;
        parkCnt <= inPark;
        enReg   <= parkEn;
      end
      if (!started) begin
        started  <= 1'b1;
        phaseReg <= '0;
        tickCnt  <= '0;
      end else if (lastTick) begin
        tickCnt  <= '0;
        phaseReg <= phaseReg + 1'b1;
      end else begin
        tickCnt <= tickCnt + ONE;
      end
    end
  end

  always_comb begin
    ctrl.active  = started;
    ctrl.phase   = phaseReg;
    ctrl.park    = started && enReg && (tickCnt < parkCnt);
    ctrl.loadPix = frameLoad;
  end

  // R2: the last tick of a running phase moves to the next phase
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (started && tick && lastTick) |=> (phaseReg == $past(phaseReg) + 1'b1));

  // R10: without a tick the sequencer position holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(phaseReg) && $stable(tickCnt)));

  // R8: the parking interval always ends before the phase does
  a_r8_park_clamp: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (parkCnt < lenReg));
endmodule

// File: rtl/lcd_mux_seq_datapath.sv
module lcd_mux_seq_datapath
  import lcd_mux_seq_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqCtrl_t               ctrl,
  input  logic [4*NUM_SEG-1:0]   pixData,
  output logic [2*NUM_COM-1:0]   comLevel,
  output logic [2*NUM_SEG-1:0]   segLevel
);
  logic [NUM_COM-1:0][NUM_SEG-1:0] pixReg;
  logic [NUM_SEG-1:0] pixRow;
  logic               oddPhase;
  logic [1:0]         selCom;
  logic [1:0]         nonSelLvl;
  logic [1:0]         selLvl;
  logic [1:0]         onLvl;
  logic [1:0]         offLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixReg <= '0;
    else if (ctrl.loadPix) pixReg <= pixData;
  end

  assign oddPhase  = ctrl.phase[0];
  assign selCom    = ctrl.phase[PH_W-1:1];
  assign nonSelLvl = oddPhase ? LVL_1V : LVL_2V;
  assign selLvl    = oddPhase ? LVL_3V : LVL_0V;
  assign onLvl     = oddPhase ? LVL_0V : LVL_3V;
  assign offLvl    = oddPhase ? LVL_2V : LVL_1V;
  assign pixRow    = pixReg[selCom];

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    always_comb begin
      if (!ctrl.active) comLevel[2*k+:2] = LVL_2V;
      else if (selCom == k) comLevel[2*k+:2] = selLvl;
      else comLevel[2*k+:2] = nonSelLvl;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_comb begin
      if (!ctrl.active) segLevel[2*s+:2] = LVL_2V;
      else if (ctrl.park) segLevel[2*s+:2] = nonSelLvl;
      else segLevel[2*s+:2] = pixRow[s] ? onLvl : offLvl;
    end
  end

  // Checker-side view of the common outputs
  logic [NUM_COM-1:0] atShared;
  for (genvar k = 0; k < NUM_COM; k++) begin : g_chk
    assign atShared[k] = (comLevel[2*k+:2] == (oddPhase ? 2'd1 : 2'd2));
  end

  // R4: three commons share the non-selected level in every running phase
  a_r4_three_shared: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> ($countones(atShared) == 3));

  // R1: before the first tick every output rests at code 2
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> (comLevel == {NUM_COM{2'd2}} && segLevel == {NUM_SEG{2'd2}}));

  // R6: while parking, all segments match the shared common level
  a_r6_park_level: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.park |-> (segLevel == {NUM_SEG{oddPhase ? 2'd1 : 2'd2}}));
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_mux_seq_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int CNT_W   = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [CNT_W-1:0]     phaseLen,
  input  logic [CNT_W-1:0]     parkLen,
  input  logic                 parkEn,
  input  logic [4*NUM_SEG-1:0] pixData,
  output logic [2:0]           phase,
  output logic [7:0]           comLevel,
  output logic [2*NUM_SEG-1:0] segLevel
);
  seqCtrl_t ctrl;

  lcd_mux_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .phaseLen(phaseLen), .parkLen(parkLen), .parkEn(parkEn),
    .ctrl(ctrl)
  );

  lcd_mux_seq_datapath #(.NUM_SEG(NUM_SEG)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pixData(pixData),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  assign phase = ctrl.phase;
endmodule

// File: tb/lcd_mux_seq_test.sv
module lcd_mux_seq_test;
  localparam int NS = 8;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [CW-1:0] phaseLen = 6'd2;
  logic [CW-1:0] parkLen = 6'd0;
  logic parkEn = 1'b0;
  logic [4*NS-1:0] pixData = '0;
  logic [2:0] phase;
  logic [7:0] comLevel;
  logic [2*NS-1:0] segLevel;

  int checks = 0;
  int errors = 0;

  // bench-side frame model
  bit mStarted = 0;
  int mPhase = 0, mCnt = 0, mLen = 1, mPark = 0;
  bit mEn = 0;
  logic [4*NS-1:0] mPix = '0;

  always #2.5 clk = ~clk;

  lcd_mux_seq #(.NUM_SEG(NS), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .phaseLen(phaseLen),
    .parkLen(parkLen), .parkEn(parkEn), .pixData(pixData),
    .phase(phase), .comLevel(comLevel), .segLevel(segLevel)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (phase %0d cnt %0d)", tag, act, exp, mPhase, mCnt);
    end
  endtask

  function automatic void modelLoad();
    mLen = (phaseLen == 0) ? 1 : int'(phaseLen);
    mPark = (int'(parkLen) >= mLen) ? mLen - 1 : int'(parkLen);
    mEn = parkEn;
    mPix = pixData;
  endfunction

  function automatic void modelTick();
    if (!mStarted) begin
      modelLoad(); mStarted = 1; mPhase = 0; mCnt = 0;
    end else if (mCnt == mLen - 1) begin
      if (mPhase == 7) modelLoad();
      mCnt = 0; mPhase = (mPhase + 1) % 8;
    end else mCnt++;
  endfunction

  task automatic checkAll(string segTag);
    logic [7:0] eCom;
    logic [2*NS-1:0] eSeg;
    bit odd = mPhase[0];
    for (int k = 0; k < 4; k++)
      eCom[2*k+:2] = !mStarted ? 2'd2 : (mPhase / 2 == k) ? (odd ? 2'd3 : 2'd0) : (odd ? 2'd1 : 2'd2);
    for (int s = 0; s < NS; s++) begin
      if (!mStarted) eSeg[2*s+:2] = 2'd2;
      else if (mEn && mCnt < mPark) eSeg[2*s+:2] = odd ? 2'd1 : 2'd2;
      else if (mPix[(mPhase / 2) * NS + s]) eSeg[2*s+:2] = odd ? 2'd0 : 2'd3;
      else eSeg[2*s+:2] = odd ? 2'd2 : 2'd1;
    end
    check("R2 phase", 32'(phase), 32'(mPhase));
    check("R3 R4 commons", 32'(comLevel), 32'(eCom));
    check(segTag, 32'(segLevel), 32'(eSeg));
  endtask

  task automatic doTick(string segTag);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    modelTick();
    checkAll(segTag);
  endtask

  task automatic runTicks(int n, string segTag);
    for (int i = 0; i < n; i++) doTick(segTag);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R1 idle segments");
    check("R1 idle phase", 32'(phase), 32'd0);
  endtask

  task automatic t_direct();
    parkEn = 0; phaseLen = 6'd2; pixData = 32'hA5C3_0FF1;
    runTicks(2 * 8 * 2, "R5 R7 direct");
  endtask

  task automatic t_park();
    parkEn = 1; phaseLen = 6'd4; parkLen = 6'd2; pixData = 32'h3C5A_F00F;
    runTicks(4 * 8 + 4 * 8, "R6 park");
  endtask

  task automatic t_clamp();
    phaseLen = 6'd3; parkLen = 6'd7; pixData = 32'hFFFF_0000;
    runTicks(3 * 8 + 3 * 8, "R8 clamp");
    phaseLen = 6'd0; parkLen = 6'd5; pixData = 32'h0000_FFFF;
    runTicks(24 + 16, "R8 zero length");
  endtask

  task automatic t_midframe();
    parkEn = 0; phaseLen = 6'd3; parkLen = 6'd1; pixData = 32'h1234_5678;
    runTicks(5, "R9 before change");
    parkEn = 1; phaseLen = 6'd2; pixData = 32'h8765_4321;
    runTicks(9, "R9 after change");
    pixData = 32'hDEAD_BEEF; parkLen = 6'd0;
    runTicks(40, "R9 next frames");
  endtask

  task automatic t_hold();
    doTick("R10 before gap");
    repeat (6) @(negedge clk);
    checkAll("R10 gap without tick");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_park();
    t_hold();
    t_clamp();
    t_midframe();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule